// File: doc/BRIEF.md
# Split-Carry Synchronous Up-Counter

This block is a free-running binary up-counter. It replaces a wide counter built from a chain of toggle flops with a fully synchronous design that holds a high clock rate. Its only control is an asynchronous clear. It advances by one on every rising clock edge and drives its whole value in parallel on one output bus.

For wide settings the count is split into a lower field and an upper field. The lower field registers a carry flag one cycle before it wraps. The upper field adds one only when that registered flag is set. No single carry chain then spans the full width, and the full value is still exact on every cycle. When the lower field width equals the total width, the block builds a single unsplit counter. This is the narrow 16-bit form. The default is the split 32-bit form.

Top module: `pcnt_counter`

## Requirements
- R1: While the active-low clear is low, the count output and the internal carry flag are zero. The clear takes effect without waiting for a clock edge.
- R2: On every rising clock edge with the clear high, the count increases by exactly one, modulo 2^WIDTH.
- R3: From the all-ones value, the next edge takes the count to zero.
- R4: In the split form, the upper field (bits WIDTH-1 down to LOW_W) stays unchanged on every edge unless the lower field (bits LOW_W-1 down to 0) was all-ones just before that edge. On that edge the upper field increases by one.
- R5: In the split form, the registered carry flag is high in exactly those cycles in which the lower field holds all-ones.
- R6: When LOW_W equals WIDTH, the block is one unsplit segment. It produces the same sequence as R2 and R3, and its carry flag stays low.
- R7: After the clear is released, the first rising edge gives a count of one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock, rising edge |
| arst_n | input | 1 | Asynchronous clear, active low |
| count | output | WIDTH | Current count value |

## Verification
The bench builds two copies of the block with small parameters so that every wrap is reached within a few thousand cycles. The split copy uses WIDTH=10 and LOW_W=4. Its lower field wraps every 16 cycles, which exercises the registered carry hand-off many times, and the full 10-bit wrap from all-ones to zero falls after 1024 cycles. The unsplit copy uses WIDTH=6 and LOW_W=6. It wraps every 64 cycles and shows that the single-segment form follows the same sequence. A clear applied in the middle of a count checks the asynchronous return to zero and the restart at one.

// File: rtl/pcnt_pkg.sv
package pcnt_pkg;

   // Smallest segment width the split structure accepts.
   localparam int unsigned PCNT_MIN_SEG_W = 2;

   // Width of the upper segment given the total and lower widths.
   function automatic int unsigned pcnt_upper_width(input int unsigned total_w,
                                                    input int unsigned low_w);
      return (total_w > low_w) ? (total_w - low_w) : 0;
   endfunction

   // True when the parameters ask for the split-carry variant.
   function automatic bit pcnt_is_split(input int unsigned total_w,
                                        input int unsigned low_w);
      return total_w > low_w;
   endfunction

endpackage

// File: rtl/pcnt_low_seg.sv
// Lower segment: counts every cycle and registers a flag that is high
// while the segment holds all-ones (decided one cycle ahead).
module pcnt_low_seg #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         arst_n,
   output logic [W-1:0] value_o,
   output logic         carry_o
);
   localparam logic [W-1:0] STEP     = W'(1);
   localparam logic [W-1:0] PRE_LAST = {{(W-1){1'b1}}, 1'b0};

   logic [W-1:0] value_q;
   logic         carry_q;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         value_q <= '0;
         carry_q <= 1'b0;
      end else begin
         value_q <= value_q + STEP;
         carry_q <= (value_q == PRE_LAST);
      end
   end

   assign value_o = value_q;
   assign carry_o = carry_q;
endmodule

// File: rtl/pcnt_high_seg.sv
// Upper segment: advances only on the cycle the registered carry is set.
module pcnt_high_seg #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         arst_n,
   input  logic         step_i,
   output logic [W-1:0] value_o
);
   localparam logic [W-1:0] STEP = W'(1);

   logic [W-1:0] value_q;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         value_q <= '0;
      end else if (step_i) begin
         value_q <= value_q + STEP;
      end
   end

   assign value_o = value_q;
endmodule

// File: rtl/pcnt_flat.sv
// Single-segment counter for the narrow configuration.
module pcnt_flat #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         arst_n,
   output logic [W-1:0] value_o
);
   localparam logic [W-1:0] STEP = W'(1);

   logic [W-1:0] value_q;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         value_q <= '0;
      end else begin
         value_q <= value_q + STEP;
      end
   end

   assign value_o = value_q;
endmodule

// File: rtl/pcnt_counter.sv
// Free-running up-counter; splits the carry path when LOW_W < WIDTH.
module pcnt_counter
   import pcnt_pkg::*;
#(
   parameter int unsigned WIDTH = 32,
   parameter int unsigned LOW_W = 16
) (
   input  logic             clk,
   input  logic             arst_n,
   output logic [WIDTH-1:0] count
);
   localparam bit          SPLIT = pcnt_is_split(WIDTH, LOW_W);
   localparam int unsigned HI_W  = pcnt_upper_width(WIDTH, LOW_W);

   // Registered lower-to-upper carry (constant low in the flat form).
   logic seg_carry;

   if (WIDTH < PCNT_MIN_SEG_W) begin : g_bad_width
      $error("pcnt_counter: WIDTH must be at least %0d", PCNT_MIN_SEG_W);
   end
   if (LOW_W < PCNT_MIN_SEG_W || LOW_W > WIDTH) begin : g_bad_low
      $error("pcnt_counter: LOW_W must lie in [%0d, WIDTH]", PCNT_MIN_SEG_W);
   end

   if (SPLIT) begin : g_split
      logic [LOW_W-1:0] low_val;
      logic [HI_W-1:0]  high_val;
      logic             low_carry;

      pcnt_low_seg #(.W(LOW_W)) u_low (
         .clk     (clk),
         .arst_n  (arst_n),
         .value_o (low_val),
         .carry_o (low_carry)
      );

      pcnt_high_seg #(.W(HI_W)) u_high (
         .clk     (clk),
         .arst_n  (arst_n),
         .step_i  (low_carry),
         .value_o (high_val)
      );

      assign count     = {high_val, low_val};
      assign seg_carry = low_carry;
   end else begin : g_flat
      logic [WIDTH-1:0] flat_val;

      pcnt_flat #(.W(WIDTH)) u_flat (
         .clk     (clk),
         .arst_n  (arst_n),
         .value_o (flat_val)
      );

      assign count     = flat_val;
      assign seg_carry = 1'b0;
   end
endmodule

// File: rtl/pcnt_counter_chk.sv
// Property checker attached to pcnt_counter.
module pcnt_counter_chk #(
   parameter int unsigned WIDTH = 32,
   parameter int unsigned LOW_W = 16
) (
   input logic             clk,
   input logic             arst_n,
   input logic [WIDTH-1:0] count,
   input logic             seg_carry
);
   localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

   // R1: clear holds the output and carry flag at zero
   always @(negedge clk) begin
      if (!arst_n) begin
         assert_clear_R1: assert (count == '0 && seg_carry == 1'b0);
      end
   end

   assert_step_R2: assert property (@(posedge clk) disable iff (!arst_n)
      1'b1 |=> (count == $past(count) + ONE));

   assert_wrap_R3: assert property (@(posedge clk) disable iff (!arst_n)
      (count == '1) |=> (count == '0));

   if (LOW_W < WIDTH) begin : g_split_chk
      assert_hold_R4: assert property (@(posedge clk) disable iff (!arst_n)
         (count[LOW_W-1:0] != '1) |=> $stable(count[WIDTH-1:LOW_W]));

      assert_advance_R4: assert property (@(posedge clk) disable iff (!arst_n)
         (count[LOW_W-1:0] == '1) |=>
            (count[WIDTH-1:LOW_W] == $past(count[WIDTH-1:LOW_W]) + 1'b1));

      assert_flag_R5: assert property (@(posedge clk) disable iff (!arst_n)
         1'b1 |-> (seg_carry == (count[LOW_W-1:0] == '1)));
   end else begin : g_flat_chk
      assert_flat_R6: assert property (@(posedge clk) disable iff (!arst_n)
         1'b1 |-> (seg_carry == 1'b0));
   end
endmodule

bind pcnt_counter pcnt_counter_chk #(.WIDTH(WIDTH), .LOW_W(LOW_W)) u_chk (
   .clk       (clk),
   .arst_n    (arst_n),
   .count     (count),
   .seg_carry (seg_carry)
);

// File: tb/pcnt_counter_test.sv
`timescale 1ns/1ps
module pcnt_counter_test;
   localparam int W_S = 10;
   localparam int L_S = 4;
   localparam int W_F = 6;

   logic clk = 1'b0;
   logic arst_n = 1'b0;
   always #4 clk = ~clk;

   logic [W_S-1:0] cnt_s;
   logic [W_F-1:0] cnt_f;

   pcnt_counter #(.WIDTH(W_S), .LOW_W(L_S)) uut (
      .clk(clk), .arst_n(arst_n), .count(cnt_s));

   pcnt_counter #(.WIDTH(W_F), .LOW_W(W_F)) uut_flat (
      .clk(clk), .arst_n(arst_n), .count(cnt_f));

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   bit running = 1'b0;

   logic [W_S-1:0] q_s[$];
   logic [W_F-1:0] q_f[$];
   logic [W_S-1:0] exp_s;
   logic [W_F-1:0] exp_f;
   logic [W_S-1:0] pop_s;
   logic [W_F-1:0] pop_f;

   task automatic check_val(input string req, input longint act, input longint expv);
      checks++;
      if (act !== expv) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   // Driver: model both counters on each edge and queue the expectations.
   task automatic tick(input int n);
      repeat (n) begin
         @(posedge clk);
         if (running) begin
            exp_s = exp_s + 1'b1;
            exp_f = exp_f + 1'b1;
            q_s.push_back(exp_s);
            q_f.push_back(exp_f);
         end
      end
   endtask

   // Monitor: compare the outputs half a period after each edge.
   always @(negedge clk) begin
      if (q_s.size() > 0) begin
         pop_s = q_s.pop_front();
         if (pop_s == '0)
            check_val("R3 split wrap", longint'(cnt_s), longint'(pop_s));
         else if (pop_s[L_S-1:0] == '0)
            check_val("R4 upper step via R5 carry", longint'(cnt_s), longint'(pop_s));
         else
            check_val("R2 split step", longint'(cnt_s), longint'(pop_s));
      end
      if (q_f.size() > 0) begin
         pop_f = q_f.pop_front();
         check_val("R6 flat sequence", longint'(cnt_f), longint'(pop_f));
      end
   end

   task automatic release_and_first();
      @(negedge clk);
      arst_n  = 1'b1;
      exp_s   = '0;
      exp_f   = '0;
      running = 1'b1;
      tick(1);
      @(negedge clk);
      #1;
      check_val("R7 first after clear (split)", longint'(cnt_s), 1);
      check_val("R7 first after clear (flat)", longint'(cnt_f), 1);
   endtask

   initial begin
      repeat (2) @(negedge clk);
      #1;
      check_val("R1 reset split", longint'(cnt_s), 0);
      check_val("R1 reset flat", longint'(cnt_f), 0);
      release_and_first();
      tick(1100);
      // Clear in the middle of a cycle, with no clock edge before the check.
      @(negedge clk);
      #1;
      arst_n  = 1'b0;
      running = 1'b0;
      #1;
      check_val("R1 async clear split", longint'(cnt_s), 0);
      check_val("R1 async clear flat", longint'(cnt_f), 0);
      release_and_first();
      tick(300);
      @(negedge clk);
      #1;
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #(200000 * 8);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog R2 actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule